// File: doc/BRIEF.md
# Per-CPU Interrupt Flag Controller

This block collects interrupt events from peripherals and turns them into one interrupt request line for each processor core. For every core it holds a master gate, a mask with one bit per source, and a set of sticky flags. A peripheral reports an event as a single-cycle pulse on its numbered source line. The event is recorded only if both the master gate and that source's mask bit are open at that moment. Software reads the flags and acknowledges them by writing ones over a small word-wide register bus.

The controller is instantiated once per core inside a single top. Each copy has its own bus, its own source lines and its own register state, so one core cannot change what the other sees. Mask and gate values are sampled at the event. Opening a gate later does not bring back an event that was dropped while it was closed. Priority resolution and vector selection belong to the core.

Top module: `irqc_dual`

## Requirements
- R1: After reset, every core's gate, mask and flag registers read 0 and every request output is low.
- R2: Byte offsets are as follows: gate register 0x208, mask register 0x210, flag register 0x214. All three are 32 bits wide. The gate stores only bit 0, and its bits 31:1 read as 0.
- R3: A source pulse that arrives while gate bit 0 is 0 leaves every flag bit unchanged.
- R4: A source pulse whose mask bit is 0 leaves that flag bit unchanged.
- R5: A pulse on source n, with gate and mask bit n both 1, sets flag bit n in the next cycle. Source indices: 0 frame blank, 1 line blank, 2 line match, 3-6 timers, 7 clock chip, 8-11 DMA channels, 12 keys, 13 expansion slot, 16 inter-core sync, 17 inter-core send empty, 18 inter-core receive, 19 card transfer done, 20 card request, 21 geometry queue, 22 lid, 23 SPI, 24 radio.
- R6: Setting a mask bit after an event on that source was dropped does not set its flag.
- R7: A write to the flag register clears each bit written as 1 and keeps each bit written as 0.
- R8: The request output is high exactly while gate bit 0 is 1 and at least one flag bit is 1. Clearing the gate lowers the request and leaves the flags intact.
- R9: When a qualified pulse and a write-one-to-clear hit the same flag bit in the same cycle, the bit ends up set.
- R10: Reads of any offset other than the three registers return 0. Bits 31:25 of the mask and flag registers read as 0.
- R11: Bus writes and source pulses of one core change no register or request output of the other core.
- R12: A gate or mask write qualifies events only from the following cycle. A pulse in the same cycle as the write is judged against the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | NCPU | Per-core write strobe |
| bus_addr | input | NCPU x AW | Per-core byte offset |
| bus_wdata | input | NCPU x 32 | Per-core write data |
| bus_rdata | output | NCPU x 32 | Per-core read data, combinational from the address |
| src_pulse | input | NCPU x NSRC | Per-core source event pulses |
| irq_req | output | NCPU | Per-core interrupt request |

## Verification
A stuck or stale flag bit shows up on the flag register read and on the request line one cycle after the event or clear that should have changed it. A gate or mask that latched the wrong value shows up when the next source pulse is recorded or dropped against that value. A mix-up between the two cores shows up as a flag or request change on the core that was not driven, in the cycle after the other core's activity.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int IRQC_DW = 32;

    // register byte offsets
    localparam int OFS_GATE = 'h208;
    localparam int OFS_MASK = 'h210;
    localparam int OFS_FLAG = 'h214;

    // source line numbering
    typedef enum int {
        SRC_FRAME_BLANK = 0,
        SRC_LINE_BLANK  = 1,
        SRC_LINE_MATCH  = 2,
        SRC_TIMER0      = 3,
        SRC_CLOCK_CHIP  = 7,
        SRC_DMA0        = 8,
        SRC_KEYS        = 12,
        SRC_SLOT        = 13,
        SRC_XCORE_SYNC  = 16,
        SRC_XCORE_EMPTY = 17,
        SRC_XCORE_RECV  = 18,
        SRC_CARD_DONE   = 19,
        SRC_CARD_REQ    = 20,
        SRC_GEOM_QUEUE  = 21,
        SRC_LID         = 22,
        SRC_SPI         = 23,
        SRC_RADIO       = 24
    } irq_src_e;

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int AW   = 12,
    parameter int NSRC = 25
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       addr,
    input  logic [IRQC_DW-1:0]  wdata,
    input  logic [NSRC-1:0]     src,
    output logic                gate_q,
    output logic [NSRC-1:0]     mask_q,
    output logic [NSRC-1:0]     flag_q
);

    localparam logic [AW-1:0] A_GATE = AW'(OFS_GATE);
    localparam logic [AW-1:0] A_MASK = AW'(OFS_MASK);
    localparam logic [AW-1:0] A_FLAG = AW'(OFS_FLAG);

    typedef struct packed {
        logic            gate;
        logic [NSRC-1:0] mask;
        logic [NSRC-1:0] flag;
    } state_t;

    state_t st_q, st_d;
    logic [NSRC-1:0] set_d, clr_d;

    always_comb begin
        st_d  = st_q;
        set_d = src & st_q.mask & {NSRC{st_q.gate}};
        clr_d = '0;
        if (wr_en) begin
            unique case (addr)
                A_GATE:  st_d.gate = wdata[0];
                A_MASK:  st_d.mask = wdata[NSRC-1:0];
                A_FLAG:  clr_d     = wdata[NSRC-1:0];
                default: ;
            endcase
        end
        st_d.flag = (st_q.flag & ~clr_d) | set_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate_q = st_q.gate;
    assign mask_q = st_q.mask;
    assign flag_q = st_q.flag;

    // R3: with the gate closed no new flag appears
    a_r3_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_q |=> ((flag_q & ~$past(flag_q)) == '0));

    // R4: a new flag bit needs its mask bit open in the cycle before
    a_r4_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(mask_q)) == '0));

    // R5 and R9: qualified pulse always leaves the bit set
    a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && (src & mask_q) != '0) |=> ((flag_q & $past(src & mask_q)) == $past(src & mask_q)));

    // R7: bits written as one, with no pulse, become zero
    a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_FLAG) |=> ((flag_q & $past(wdata[NSRC-1:0] & ~src)) == '0));

    // R7: flag bits never fall without a clearing write
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_FLAG) |=> ((~flag_q & $past(flag_q)) == '0));

endmodule

// File: rtl/irqc_rdmux.sv
module irqc_rdmux
    import irqc_pkg::*;
#(
    parameter int AW   = 12,
    parameter int NSRC = 25
) (
    input  logic [AW-1:0]      addr,
    input  logic               gate,
    input  logic [NSRC-1:0]    mask,
    input  logic [NSRC-1:0]    flag,
    output logic [IRQC_DW-1:0] rdata
);

    localparam int PADW = IRQC_DW - NSRC;

    always_comb begin
        unique case (addr)
            AW'(OFS_GATE): rdata = {{(IRQC_DW-1){1'b0}}, gate};
            AW'(OFS_MASK): rdata = {{PADW{1'b0}}, mask};
            AW'(OFS_FLAG): rdata = {{PADW{1'b0}}, flag};
            default:       rdata = '0;
        endcase
    end

    // R10: unused upper bits stay zero on every read
    always_comb begin
        a_r10_upper_zero: assert (rdata[IRQC_DW-1:NSRC] == '0);
    end

endmodule

// File: rtl/irqc_dual.sv
module irqc_dual
    import irqc_pkg::*;
#(
    parameter int NCPU = 2,
    parameter int AW   = 12,
    parameter int NSRC = 25
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NCPU-1:0]                   bus_we,
    input  logic [NCPU-1:0][AW-1:0]           bus_addr,
    input  logic [NCPU-1:0][IRQC_DW-1:0]      bus_wdata,
    output logic [NCPU-1:0][IRQC_DW-1:0]      bus_rdata,
    input  logic [NCPU-1:0][NSRC-1:0]         src_pulse,
    output logic [NCPU-1:0]                   irq_req
);

    for (genvar c = 0; c < NCPU; c++) begin : g_core
        logic            gate;
        logic [NSRC-1:0] mask;
        logic [NSRC-1:0] flag;

        irqc_regs #(.AW(AW), .NSRC(NSRC)) u_regs (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (bus_we[c]),
            .addr   (bus_addr[c]),
            .wdata  (bus_wdata[c]),
            .src    (src_pulse[c]),
            .gate_q (gate),
            .mask_q (mask),
            .flag_q (flag)
        );

        irqc_rdmux #(.AW(AW), .NSRC(NSRC)) u_rd (
            .addr  (bus_addr[c]),
            .gate  (gate),
            .mask  (mask),
            .flag  (flag),
            .rdata (bus_rdata[c])
        );

        assign irq_req[c] = gate & (|flag);

        // R8: a raised request implies a flag read back as nonzero
        a_r8_req_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_req[c] && bus_addr[c] == AW'(OFS_FLAG)) |-> (bus_rdata[c] != '0));
    end

endmodule

// File: tb/sim_irqc_dual.sv
module sim_irqc_dual;
    import irqc_pkg::*;

    localparam int NCPU = 2;
    localparam int AW   = 12;
    localparam int NSRC = 25;
    localparam logic [AW-1:0] A_GATE = AW'(OFS_GATE);
    localparam logic [AW-1:0] A_MASK = AW'(OFS_MASK);
    localparam logic [AW-1:0] A_FLAG = AW'(OFS_FLAG);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCPU-1:0]               bus_we = '0;
    logic [NCPU-1:0][AW-1:0]       bus_addr = '0;
    logic [NCPU-1:0][31:0]         bus_wdata = '0;
    logic [NCPU-1:0][31:0]         bus_rdata;
    logic [NCPU-1:0][NSRC-1:0]     src_pulse = '0;
    logic [NCPU-1:0]               irq_req;

    always #4 clk = ~clk;

    irqc_dual #(.NCPU(NCPU), .AW(AW), .NSRC(NSRC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_pulse(src_pulse), .irq_req(irq_req)
    );

    typedef struct {
        int          cpu;
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int failures = 0;
    bit chk_req = 1'b0;
    bit done = 1'b0;

    // reference model built from the requirements
    bit          m_gate[NCPU];
    logic [31:0] m_mask[NCPU];
    logic [31:0] m_flag[NCPU];

    function automatic logic [31:0] m_read(int c, logic [AW-1:0] a);
        if (a == A_GATE) return {31'b0, m_gate[c]};
        if (a == A_MASK) return m_mask[c];
        if (a == A_FLAG) return m_flag[c];
        return 32'h0;
    endfunction

    task automatic step(int c, bit we, logic [AW-1:0] a, logic [31:0] d, logic [NSRC-1:0] s);
        logic [31:0] setv, clrv;
        @(posedge clk); #1;
        bus_we = '0; src_pulse = '0;
        bus_we[c] = we; bus_addr[c] = a; bus_wdata[c] = d; src_pulse[c] = s;
        setv = {7'b0, s} & m_mask[c] & {32{m_gate[c]}};
        clrv = (we && a == A_FLAG) ? (d & 32'h01FF_FFFF) : 32'h0;
        m_flag[c] = (m_flag[c] & ~clrv) | setv;
        if (we && a == A_GATE) m_gate[c] = d[0];
        if (we && a == A_MASK) m_mask[c] = d & 32'h01FF_FFFF;
    endtask

    task automatic expect_item(int c, bit is_irq, logic [AW-1:0] a, string tag);
        item_t it;
        @(posedge clk); #1;
        bus_we = '0; src_pulse = '0;
        bus_addr[c] = a;
        it.cpu = c; it.is_irq = is_irq; it.tag = tag;
        it.exp = is_irq ? {31'b0, m_gate[c] && (m_flag[c] != 0)} : m_read(c, a);
        q.push_back(it);
        chk_req = 1'b1;
        @(negedge clk); #1;
        chk_req = 1'b0;
    endtask

    task automatic rd(int c, logic [AW-1:0] a, string tag);
        expect_item(c, 1'b0, a, tag);
    endtask

    task automatic irq(int c, string tag);
        expect_item(c, 1'b1, A_FLAG, tag);
    endtask

    // monitor: pops expected items and compares at the falling edge
    always @(negedge clk) begin
        if (chk_req && q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            act = it.is_irq ? {31'b0, irq_req[it.cpu]} : bus_rdata[it.cpu];
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s cpu%0d actual=%08h expected=%08h", it.tag, it.cpu, act, it.exp);
            end
        end
    end

    initial begin
        for (int c = 0; c < NCPU; c++) begin
            m_gate[c] = 1'b0; m_mask[c] = '0; m_flag[c] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(0, A_GATE, "R1"); rd(0, A_MASK, "R1"); rd(0, A_FLAG, "R1");
        rd(1, A_FLAG, "R1"); irq(0, "R1"); irq(1, "R1");

        // R10 mask upper bits
        step(0, 1, A_MASK, 32'hFFFF_FFFF, '0);
        rd(0, A_MASK, "R10");
        // R3 gate closed
        step(0, 0, A_GATE, 0, NSRC'(1) << SRC_FRAME_BLANK);
        rd(0, A_FLAG, "R3");
        // R2 gate keeps bit 0 only
        step(0, 1, A_GATE, 32'hFFFF_FFFF, '0);
        rd(0, A_GATE, "R2");
        // R4 mask bit closed
        step(0, 1, A_MASK, 32'h01FF_FDFF, '0);
        step(0, 0, A_GATE, 0, NSRC'(1) << SRC_DMA0 + 1);
        rd(0, A_FLAG, "R4");
        // R6 late mask does not recover
        step(0, 1, A_MASK, 32'h01FF_FFFF, '0);
        rd(0, A_FLAG, "R6");
        // R5 latch
        step(0, 0, A_GATE, 0, (NSRC'(1) << SRC_SPI) | (NSRC'(1) << SRC_XCORE_SYNC));
        rd(0, A_FLAG, "R5"); irq(0, "R8");
        // R7 write one to clear
        step(0, 1, A_FLAG, (32'h1 << SRC_XCORE_SYNC) | (32'h1 << 3), '0);
        rd(0, A_FLAG, "R7");
        // R9 event wins over clear
        step(0, 1, A_FLAG, 32'h1 << SRC_SPI, NSRC'(1) << SRC_SPI);
        rd(0, A_FLAG, "R9");
        step(0, 1, A_FLAG, 32'h1 << SRC_SPI, NSRC'(1) << 4);
        rd(0, A_FLAG, "R7");
        // R8 closing gate drops request, keeps flags
        step(0, 1, A_GATE, 0, '0);
        irq(0, "R8"); rd(0, A_FLAG, "R8");
        // R12 same-cycle writes use old values
        step(0, 1, A_GATE, 1, '0);
        step(0, 1, A_MASK, 0, '0);
        step(0, 1, A_MASK, 32'h1 << SRC_CLOCK_CHIP, NSRC'(1) << SRC_CLOCK_CHIP);
        rd(0, A_FLAG, "R12");
        step(0, 1, A_MASK, 0, NSRC'(1) << SRC_CLOCK_CHIP);
        rd(0, A_FLAG, "R12");
        step(0, 1, A_GATE, 0, '0);
        step(0, 1, A_MASK, 32'hFFFF_FFFF, NSRC'(1) << SRC_RADIO);
        step(0, 1, A_GATE, 1, NSRC'(1) << SRC_RADIO);
        rd(0, A_FLAG, "R12");
        // R10 unmapped offsets and upper flag bits
        rd(0, 12'h20C, "R10"); rd(0, 12'h000, "R10"); rd(0, A_FLAG, "R10");
        // R11 independence
        step(1, 1, A_GATE, 1, '0);
        step(1, 1, A_MASK, 32'h1 << SRC_LID, '0);
        step(1, 0, A_GATE, 0, NSRC'(1) << SRC_LID);
        rd(1, A_FLAG, "R11"); irq(1, "R11"); rd(0, A_FLAG, "R11"); rd(0, A_MASK, "R11");
        step(0, 1, A_FLAG, 32'hFFFF_FFFF, '0);
        rd(0, A_FLAG, "R7"); irq(0, "R8"); irq(1, "R11"); rd(1, A_FLAG, "R11");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule